// File: doc/BRIEF.md
# Configurable GPIO Port Controller

This block controls an eight-pin general-purpose I/O port. Four registers sit on a small single-cycle register bus. They hold the pin direction, the output data, a per-pin input pull-up select and a per-pin open-drain select. From these registers the block drives four signals for each pad: an output enable, an output value, a high-side driver enable and a pull-up enable. A pull-up can only switch on for a pin set as an input. An operating-mode input also decides which pull-up bits have any effect.

Pin levels enter through a two-flop synchroniser. A read of the port address returns a mix: the data register bit for each output pin and the synchronised pin level for each input pin.

A small power-state machine reacts to the two standby inputs:
- **PWR_RUN** is the normal state. It moves to PWR_HARD when `hw_stby` is high. Otherwise it moves to PWR_SOFT when `sw_stby` is high.
- **PWR_SOFT** moves to PWR_HARD when `hw_stby` is high. It moves back to PWR_RUN when `sw_stby` goes low.
- **PWR_HARD** stays while `hw_stby` is high. It moves to PWR_RUN on the first cycle after `hw_stby` falls.

Register writes are accepted only in PWR_RUN, and only while neither standby input is high. Hardware standby clears all four registers. Software standby holds every register.

Top module: `gpio_port_ctl`

## Requirements
- R1: While `rst_n` is low, and after it rises, all four registers read 0x00 and `pin_oe`, `pin_out`, `pin_hs_en` and `pin_pu_en` are all 0x00.
- R2: `pin_pu_en[i]` is 1 only when direction bit i is 0 (input), pull-up bit i is 1, and the mode mask allows bit i.
- R3: The mode mask depends on `mode`. It is 0xFF for mode 4 or 7. It is 0xE0 (bits 7..5) for mode 1, 2, 5 or 6. It is 0x00 for mode 0 or 3.
- R4: For an output pin with open-drain bit 0 (push-pull), `pin_oe` is 1 and `pin_hs_en` is 1. For an output pin with open-drain bit 1, a data bit of 0 gives `pin_oe`=1 and `pin_hs_en`=0, and a data bit of 1 gives `pin_oe`=0. `pin_out` always equals the data register.
- R5: A clock edge with `hw_stby` high clears all four registers to 0x00. Writes are ignored while `hw_stby` is high.
- R6: While in PWR_SOFT, or while `sw_stby` is high, writes are ignored. The registers and the pad outputs keep their values.
- R7: The address map is 0 for direction, 1 for port data, 2 for pull-up and 3 for open-drain. A read of address 1 returns `(dir & data) | (~dir & synced_pins)`.
- R8: A change on `pin_in` shows up in a port read after exactly two rising edges, and not after one.
- R9: A write with `wr_en` high in PWR_RUN updates the addressed register at that clock edge. `rd_data` is combinational from `addr`.
- R10: The state moves to PWR_HARD one edge after `hw_stby` is sampled high. It moves from PWR_HARD to PWR_RUN on the first edge with `hw_stby` low, and a write on that edge is still ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hw_stby | input | 1 | Hardware standby request |
| sw_stby | input | 1 | Software standby request |
| mode | input | 3 | Operating mode, selects the pull-up mask |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register select |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data for `addr` |
| pin_in | input | 8 | Raw pin levels |
| pin_oe | output | 8 | Per-pin output enable |
| pin_out | output | 8 | Per-pin output value |
| pin_hs_en | output | 8 | Per-pin high-side driver enable |
| pin_pu_en | output | 8 | Per-pin pull-up enable |

## Verification
The pull-up logic is driven with direction patterns that split the pins into inputs and outputs. It is tried under a full mask mode, a partial mask mode and a disabled mode. This separates the direction gate from the mode mask.

The pad drivers are checked with mixed open-drain and data patterns. Each of the three driver cases then appears on different pins at once.

The port read path is driven with a direction that splits the pins. This shows that register bits and pin bits are merged per pin. Sampling after one edge and after two edges pins down the synchroniser depth.

The standby tests start from non-zero registers. They then separate clearing (hardware standby) from holding (software standby). They also probe the blocked write on the exit edge from PWR_HARD.

// File: rtl/gpio_port_pkg.sv
`timescale 1ns/1ps
package gpio_port_pkg;
    localparam int NPIN   = 8;
    localparam int ADDR_W = 2;
    localparam int MODE_W = 3;

    typedef enum logic [1:0] {
        PWR_RUN  = 2'd0,
        PWR_SOFT = 2'd1,
        PWR_HARD = 2'd2
    } pwr_state_t;

    localparam logic [ADDR_W-1:0] REG_DIR  = 2'd0;
    localparam logic [ADDR_W-1:0] REG_DATA = 2'd1;
    localparam logic [ADDR_W-1:0] REG_PULL = 2'd2;
    localparam logic [ADDR_W-1:0] REG_OPEN = 2'd3;
endpackage

// File: rtl/gpio_pwr_fsm.sv
`timescale 1ns/1ps
module gpio_pwr_fsm
    import gpio_port_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic hw_stby,
    input  logic sw_stby,
    output logic wr_allow
);
    pwr_state_t state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= PWR_RUN;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d  = state_q;
        wr_allow = 1'b0;
        unique case (state_q)
            PWR_RUN: begin
                wr_allow = !hw_stby && !sw_stby;
                if (hw_stby)      state_d = PWR_HARD;
                else if (sw_stby) state_d = PWR_SOFT;
            end
            PWR_SOFT: begin
                if (hw_stby)       state_d = PWR_HARD;
                else if (!sw_stby) state_d = PWR_RUN;
            end
            PWR_HARD: begin
                if (!hw_stby) state_d = PWR_RUN;
            end
            default: state_d = PWR_RUN;
        endcase
    end

    assert_hw_enters_hard_R10: assert property (@(posedge clk) disable iff (!rst_n)
        hw_stby |=> (state_q == PWR_HARD));
    assert_hard_exits_run_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PWR_HARD && !hw_stby) |=> (state_q == PWR_RUN));
    assert_soft_no_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PWR_SOFT) |-> !wr_allow);
endmodule

// File: rtl/gpio_port_regs.sv
`timescale 1ns/1ps
module gpio_port_regs
    import gpio_port_pkg::*;
#(
    parameter int W = NPIN
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hw_clear,
    input  logic              wr_allow,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [W-1:0]      wr_data,
    output logic [W-1:0]      dir_q,
    output logic [W-1:0]      data_q,
    output logic [W-1:0]      pull_q,
    output logic [W-1:0]      open_q
);
    logic do_wr;
    assign do_wr = wr_en && wr_allow && !hw_clear;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dir_q  <= '0;
            data_q <= '0;
            pull_q <= '0;
            open_q <= '0;
        end else if (hw_clear) begin
            dir_q  <= '0;
            data_q <= '0;
            pull_q <= '0;
            open_q <= '0;
        end else if (do_wr) begin
            unique case (addr)
                REG_DIR:  dir_q  <= wr_data;
                REG_DATA: data_q <= wr_data;
                REG_PULL: pull_q <= wr_data;
                REG_OPEN: open_q <= wr_data;
                default: ;
            endcase
        end
    end

    assert_hw_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
        hw_clear |=> (dir_q == '0 && data_q == '0 && pull_q == '0 && open_q == '0));
    assert_blocked_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_allow && !hw_clear) |=> ($stable(dir_q) && $stable(data_q) &&
                                      $stable(pull_q) && $stable(open_q)));
    assert_write_lands_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_allow && !hw_clear && addr == REG_PULL) |=> (pull_q == $past(wr_data)));
endmodule

// File: rtl/gpio_pin_sync.sv
`timescale 1ns/1ps
module gpio_pin_sync #(
    parameter int W      = 8,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [W-1:0] stage_q [STAGES];

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stage_q[0] <= '0;
                else        stage_q[0] <= din;
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stage_q[g] <= '0;
                else        stage_q[g] <= stage_q[g-1];
            end
        end
    end

    assign dout = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_pad_ctl.sv
`timescale 1ns/1ps
module gpio_pad_ctl #(
    parameter int W = 8
) (
    input  logic [W-1:0] dir,
    input  logic [W-1:0] data,
    input  logic [W-1:0] pull,
    input  logic [W-1:0] open,
    input  logic [W-1:0] pu_mask,
    output logic [W-1:0] oe,
    output logic [W-1:0] out,
    output logic [W-1:0] hs_en,
    output logic [W-1:0] pu_en
);
    for (genvar i = 0; i < W; i++) begin : g_pin
        logic releasing;
        always_comb begin
            releasing = open[i] && data[i];
            oe[i]     = dir[i] && !releasing;
            out[i]    = data[i];
            hs_en[i]  = dir[i] && !open[i];
            pu_en[i]  = !dir[i] && pull[i] && pu_mask[i];
        end
    end
endmodule

// File: rtl/gpio_port_ctl.sv
`timescale 1ns/1ps
module gpio_port_ctl
    import gpio_port_pkg::*;
#(
    parameter int W           = NPIN,
    parameter int SYNC_STAGES = 2,
    parameter int PART_LOW    = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hw_stby,
    input  logic              sw_stby,
    input  logic [MODE_W-1:0] mode,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [W-1:0]      wr_data,
    output logic [W-1:0]      rd_data,
    input  logic [W-1:0]      pin_in,
    output logic [W-1:0]      pin_oe,
    output logic [W-1:0]      pin_out,
    output logic [W-1:0]      pin_hs_en,
    output logic [W-1:0]      pin_pu_en
);
    localparam logic [W-1:0] MASK_ALL  = '1;
    localparam logic [W-1:0] MASK_PART = ~((W'(1) << PART_LOW) - W'(1));

    logic         wr_allow;
    logic [W-1:0] dir_q, data_q, pull_q, open_q, synced, pu_mask, port_view;
    logic         mode_full, mode_part;

    gpio_pwr_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .hw_stby(hw_stby), .sw_stby(sw_stby),
        .wr_allow(wr_allow)
    );

    gpio_port_regs #(.W(W)) u_regs (
        .clk(clk), .rst_n(rst_n), .hw_clear(hw_stby), .wr_allow(wr_allow),
        .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
        .dir_q(dir_q), .data_q(data_q), .pull_q(pull_q), .open_q(open_q)
    );

    gpio_pin_sync #(.W(W), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .din(pin_in), .dout(synced)
    );

    always_comb begin
        mode_full = 1'b0;
        mode_part = 1'b0;
        case (mode)
            3'd4, 3'd7:             mode_full = 1'b1;
            3'd1, 3'd2, 3'd5, 3'd6: mode_part = 1'b1;
            default: ;
        endcase
        pu_mask = mode_full ? MASK_ALL : (mode_part ? MASK_PART : '0);
    end

    gpio_pad_ctl #(.W(W)) u_pad (
        .dir(dir_q), .data(data_q), .pull(pull_q), .open(open_q), .pu_mask(pu_mask),
        .oe(pin_oe), .out(pin_out), .hs_en(pin_hs_en), .pu_en(pin_pu_en)
    );

    assign port_view = (dir_q & data_q) | (~dir_q & synced);

    always_comb begin
        unique case (addr)
            REG_DIR:  rd_data = dir_q;
            REG_DATA: rd_data = port_view;
            REG_PULL: rd_data = pull_q;
            REG_OPEN: rd_data = open_q;
            default:  rd_data = '0;
        endcase
    end

    assert_pu_not_driving_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_pu_en & pin_oe) == '0);
    assert_mode_off_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 3'd0 || mode == 3'd3) |-> (pin_pu_en == '0));
    assert_mode_part_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 3'd1 || mode == 3'd2 || mode == 3'd5 || mode == 3'd6)
            |-> ((pin_pu_en & ~MASK_PART) == '0));
    assert_hs_needs_oe_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_hs_en & ~pin_oe) == '0);
    assert_hw_pads_off_R5: assert property (@(posedge clk) disable iff (!rst_n)
        hw_stby |=> (pin_oe == '0 && pin_pu_en == '0 && pin_hs_en == '0));
endmodule

// File: tb/tb_gpio_port_ctl.sv
`timescale 1ns/1ps
module tb_gpio_port_ctl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       hw_stby = 1'b0, sw_stby = 1'b0;
    logic [2:0] mode = 3'd4;
    logic       wr_en = 1'b0;
    logic [1:0] addr = 2'd0;
    logic [7:0] wr_data = 8'h00, pin_in = 8'h00;
    logic [7:0] rd_data, pin_oe, pin_out, pin_hs_en, pin_pu_en;
    int n_chk = 0, n_fail = 0;

    always #2 clk = ~clk;

    gpio_port_ctl dut (
        .clk(clk), .rst_n(rst_n), .hw_stby(hw_stby), .sw_stby(sw_stby), .mode(mode),
        .wr_en(wr_en), .addr(addr), .wr_data(wr_data), .rd_data(rd_data),
        .pin_in(pin_in), .pin_oe(pin_oe), .pin_out(pin_out),
        .pin_hs_en(pin_hs_en), .pin_pu_en(pin_pu_en)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk); wr_en = 1'b1; addr = a; wr_data = d;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic rd_chk(input string req, input logic [1:0] a, input logic [7:0] exp);
        addr = a; #0.5;
        chk(req, rd_data, exp);
    endtask

    function automatic logic [7:0] mask_of(input logic [2:0] m);
        case (m)
            3'd4, 3'd7:             return 8'hFF;
            3'd1, 3'd2, 3'd5, 3'd6: return 8'hE0;
            default:                return 8'h00;
        endcase
    endfunction

    task automatic t_reset();
        #0.5;
        chk("R1 oe in reset", pin_oe, 8'h00);
        @(negedge clk); rst_n = 1'b1;
        @(negedge clk);
        for (int a = 0; a < 4; a++) rd_chk("R1 reg after reset", 2'(a), 8'h00);
        chk("R1 oe", pin_oe, 8'h00);
        chk("R1 out", pin_out, 8'h00);
        chk("R1 hs", pin_hs_en, 8'h00);
        chk("R1 pu", pin_pu_en, 8'h00);
    endtask

    task automatic t_rw();
        wr(2'd0, 8'hC3); rd_chk("R9 dir write", 2'd0, 8'hC3);
        wr(2'd2, 8'h5A); rd_chk("R9 pull write", 2'd2, 8'h5A);
        wr(2'd3, 8'h81); rd_chk("R7 open addr", 2'd3, 8'h81);
        wr(2'd1, 8'hFF); rd_chk("R7 port mixes data", 2'd1, 8'hC3);
        rd_chk("R7 dir unchanged", 2'd0, 8'hC3);
    endtask

    task automatic t_pullup();
        logic [2:0] modes [5] = '{3'd4, 3'd1, 3'd3, 3'd7, 3'd0};
        wr(2'd3, 8'h00);
        wr(2'd2, 8'hFF);
        wr(2'd0, 8'h0F);
        for (int k = 0; k < 5; k++) begin
            mode = modes[k]; #0.5;
            chk($sformatf("R3 mode %0d pu", modes[k]), pin_pu_en, mask_of(modes[k]) & 8'hF0);
        end
        mode = 3'd7;
        wr(2'd0, 8'h00); #0.5;
        chk("R2 all inputs pu", pin_pu_en, 8'hFF);
        wr(2'd2, 8'h3C); #0.5;
        chk("R2 pull bits select", pin_pu_en, 8'h3C);
        mode = 3'd5; #0.5;
        chk("R3 partial mask", pin_pu_en, 8'h20);
        mode = 3'd4;
    endtask

    task automatic t_opendrain();
        wr(2'd0, 8'hFF);
        wr(2'd3, 8'hF0);
        wr(2'd1, 8'hA5);
        wr(2'd2, 8'hFF); #0.5;
        chk("R4 oe", pin_oe, 8'h5F);
        chk("R4 hs", pin_hs_en, 8'h0F);
        chk("R4 out", pin_out, 8'hA5);
        chk("R2 outputs no pu", pin_pu_en, 8'h00);
    endtask

    task automatic t_pinread();
        wr(2'd2, 8'h00);
        wr(2'd3, 8'h00);
        wr(2'd0, 8'hF0);
        wr(2'd1, 8'h30);
        pin_in = 8'h00;
        repeat (3) @(negedge clk);
        pin_in = 8'h5A;
        @(negedge clk); rd_chk("R8 one edge not yet", 2'd1, 8'h30);
        @(negedge clk); rd_chk("R8 two edges seen", 2'd1, 8'h3A);
    endtask

    task automatic t_hwstby();
        wr(2'd2, 8'h11);
        wr(2'd3, 8'h22);
        @(negedge clk); hw_stby = 1'b1;
        @(negedge clk);
        for (int a = 0; a < 4; a++) begin
            if (a == 1) continue;
            rd_chk("R5 cleared", 2'(a), 8'h00);
        end
        chk("R5 oe off", pin_oe, 8'h00);
        wr_en = 1'b1; addr = 2'd2; wr_data = 8'h77;
        @(negedge clk);
        wr_en = 1'b0; rd_chk("R5 write ignored", 2'd2, 8'h00);
        hw_stby = 1'b0; wr_en = 1'b1; addr = 2'd3; wr_data = 8'h66;
        @(negedge clk); wr_en = 1'b0;
        rd_chk("R10 exit edge write ignored", 2'd3, 8'h00);
        wr(2'd3, 8'h44); rd_chk("R10 run write ok", 2'd3, 8'h44);
    endtask

    task automatic t_swstby();
        wr(2'd0, 8'hF0);
        wr(2'd1, 8'hC0);
        @(negedge clk); sw_stby = 1'b1;
        @(negedge clk);
        wr(2'd0, 8'h0F);
        wr(2'd3, 8'h00);
        rd_chk("R6 dir held", 2'd0, 8'hF0);
        rd_chk("R6 open held", 2'd3, 8'h44);
        chk("R6 oe held", pin_oe, 8'hB0);
        chk("R6 hs held", pin_hs_en, 8'hB0);
        sw_stby = 1'b0;
        @(negedge clk);
        wr(2'd0, 8'h0F); rd_chk("R10 soft exit write ok", 2'd0, 8'h0F);
    endtask

    initial begin
        t_reset();
        t_rw();
        t_pullup();
        t_opendrain();
        t_pinread();
        t_hwstby();
        t_swstby();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule